// File: doc/BRIEF.md
# Memory-to-FIFO Message Sequencer

This block copies a run of 16-bit words from a word-addressed nonvolatile memory into a small FIFO that a host drains. A message command carries two bytes: a start address and a length code. The length code holds the word count minus one, so a single byte covers every message length from 1 to 256 words. Once a command is accepted, the block enters message mode. It walks the addresses upward, and the address wraps from the top of the 8-bit space back to zero. Each word is fetched through a request/valid handshake whose latency is not fixed, and each returned word is pushed into the FIFO.

The host reads the FIFO at any time. While a message is being copied, the FIFO is read-only from the host side. When no message is running, host writes push words into the FIFO as an ordinary queue. When the FIFO is full, the sequencer holds off its next memory request until the host frees a slot. A busy flag covers the whole message. A one-cycle done pulse marks its end.

Top module: `msg_stream_seq`

## Requirements
- R1: After reset, busy_o, done_o and mem_req_o are low, fifo_empty_o is high and fifo_count_o is 0.
- R2: A command with length code N pushes exactly N+1 words into the FIFO and then ends the message; N=0 gives 1 word and N=255 gives 256 words.
- R3: Word k of a message (k counted from 0) equals the memory word at address start+k, and the words leave the FIFO in that order.
- R4: The read address is 8 bits wide and wraps from 255 to 0 when a message runs past the end of the address space.
- R5: busy_o is high from the cycle after the command is accepted until the last word is pushed. done_o is then high for exactly one cycle, the same cycle in which busy_o first reads low.
- R6: A command that arrives while busy_o is high is ignored; the running message keeps its length and addresses.
- R7: Host writes to the FIFO are ignored while busy_o is high. When busy_o is low, a host write pushes host_wdata_i, as long as the FIFO is not full.
- R8: mem_req_o stays low while fifo_full_o is high, and the sequencer resumes after a host read frees a slot; the FIFO never holds more than FIFO_DEPTH words.
- R9: At most one memory read is outstanding. After mem_req_o is high for one cycle, no new request is made until mem_rvalid_i returns the data, whatever the latency.
- R10: The FIFO is first-in first-out with the head word visible on fifo_rdata_o. A host read pops one word, and a host read while the FIFO is empty has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cmd_valid_i | input | 1 | Message command strobe |
| cmd_len_i | input | 8 | Length code, word count minus one |
| cmd_addr_i | input | 8 | Start address of the message |
| mem_req_o | output | 1 | Memory read request, one cycle per word |
| mem_addr_o | output | 8 | Memory word address |
| mem_rvalid_i | input | 1 | Memory read data valid |
| mem_rdata_i | input | 16 | Memory read data |
| host_wr_i | input | 1 | Host FIFO write strobe |
| host_wdata_i | input | 16 | Host FIFO write data |
| host_rd_i | input | 1 | Host FIFO read (pop) strobe |
| fifo_rdata_o | output | 16 | FIFO head word |
| fifo_empty_o | output | 1 | FIFO holds no word |
| fifo_full_o | output | 1 | FIFO holds FIFO_DEPTH words |
| fifo_count_o | output | 3 | Number of words in the FIFO |
| busy_o | output | 1 | Message in progress |
| done_o | output | 1 | One-cycle pulse at message end |

## Verification
The hardest state to reach is the stall: a full FIFO while words are still left in the message, with no read outstanding. This state only arises when the host stops reading for long enough. In one read pattern the bench withholds all reads until fifo_full_o rises. It then holds that state for several cycles, checking that no request appears, and drains the FIFO afterwards. The bench also varies the memory latency with the address and injects a stray command and a host write in mid-message. Messages that cross address 255 and the 256-word maximum cover the wrap and the length coding.

// File: rtl/msg_stream_pkg.sv
package msg_stream_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE,
    SEQ_REQ,
    SEQ_WAIT
  } seq_state_e;
endpackage

// File: rtl/msg_stream_fifo.sv
module msg_stream_fifo #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 4,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              rd_en_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              empty_o,
  output logic              full_o,
  output logic [CNT_W-1:0]  count_o
);
  logic [DATA_W-1:0] store_q [DEPTH];
  logic [PTR_W-1:0]  wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              do_wr, do_rd;

  function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign count_o = cnt_q;
  assign rdata_o = store_q[rd_ptr_q];
  assign do_wr   = wr_en_i && !full_o;
  assign do_rd   = rd_en_i && !empty_o;

  always_ff @(posedge clk_i) begin
    if (do_wr) store_q[wr_ptr_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (do_wr) wr_ptr_q <= ptr_next(wr_ptr_q);
      if (do_rd) rd_ptr_q <= ptr_next(rd_ptr_q);
      case ({do_wr, do_rd})
        2'b10:   cnt_q <= cnt_q + CNT_W'(1);
        2'b01:   cnt_q <= cnt_q - CNT_W'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/msg_stream_ctrl.sv
module msg_stream_ctrl
  import msg_stream_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LEN_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  input  logic [LEN_W-1:0]  cmd_len_i,
  input  logic [ADDR_W-1:0] cmd_addr_i,
  input  logic              fifo_full_i,
  input  logic              mem_rvalid_i,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              push_o,
  output logic              busy_o,
  output logic              done_o
);
  seq_state_e        state_q;
  logic [ADDR_W-1:0] addr_q;
  logic [LEN_W-1:0]  rem_q;   // words left after the current one
  logic              done_q;

  // request only when a slot is guaranteed for the returning word
  assign mem_req_o  = (state_q == SEQ_REQ) && !fifo_full_i;
  assign mem_addr_o = addr_q;
  assign push_o     = (state_q == SEQ_WAIT) && mem_rvalid_i;
  assign busy_o     = (state_q != SEQ_IDLE);
  assign done_o     = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SEQ_IDLE;
      addr_q  <= '0;
      rem_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        SEQ_IDLE: begin
          if (cmd_valid_i) begin
            addr_q  <= cmd_addr_i;
            rem_q   <= cmd_len_i;
            state_q <= SEQ_REQ;
          end
        end
        SEQ_REQ: begin
          if (mem_req_o) state_q <= SEQ_WAIT;
        end
        SEQ_WAIT: begin
          if (mem_rvalid_i) begin
            if (rem_q == '0) begin
              state_q <= SEQ_IDLE;
              done_q  <= 1'b1;
            end else begin
              rem_q   <= rem_q - LEN_W'(1);
              addr_q  <= addr_q + ADDR_W'(1);
              state_q <= SEQ_REQ;
            end
          end
        end
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/msg_stream_seq.sv
module msg_stream_seq #(
  parameter int DATA_W     = 16,
  parameter int ADDR_W     = 8,
  parameter int LEN_W      = 8,
  parameter int FIFO_DEPTH = 4,
  localparam int CNT_W     = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  input  logic [LEN_W-1:0]  cmd_len_i,
  input  logic [ADDR_W-1:0] cmd_addr_i,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic              mem_rvalid_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  input  logic              host_wr_i,
  input  logic [DATA_W-1:0] host_wdata_i,
  input  logic              host_rd_i,
  output logic [DATA_W-1:0] fifo_rdata_o,
  output logic              fifo_empty_o,
  output logic              fifo_full_o,
  output logic [CNT_W-1:0]  fifo_count_o,
  output logic              busy_o,
  output logic              done_o
);
  logic              seq_push;
  logic              fifo_wr;
  logic [DATA_W-1:0] fifo_wdata;

  msg_stream_ctrl #(
    .ADDR_W(ADDR_W),
    .LEN_W (LEN_W)
  ) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cmd_valid_i (cmd_valid_i),
    .cmd_len_i   (cmd_len_i),
    .cmd_addr_i  (cmd_addr_i),
    .fifo_full_i (fifo_full_o),
    .mem_rvalid_i(mem_rvalid_i),
    .mem_req_o   (mem_req_o),
    .mem_addr_o  (mem_addr_o),
    .push_o      (seq_push),
    .busy_o      (busy_o),
    .done_o      (done_o)
  );

  // message mode owns the write side; host writes are dropped meanwhile
  assign fifo_wr    = busy_o ? seq_push : host_wr_i;
  assign fifo_wdata = busy_o ? mem_rdata_i : host_wdata_i;

  msg_stream_fifo #(
    .DATA_W(DATA_W),
    .DEPTH (FIFO_DEPTH)
  ) u_fifo (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_en_i(fifo_wr),
    .wdata_i(fifo_wdata),
    .rd_en_i(host_rd_i),
    .rdata_o(fifo_rdata_o),
    .empty_o(fifo_empty_o),
    .full_o (fifo_full_o),
    .count_o(fifo_count_o)
  );
endmodule

// File: rtl/msg_stream_chk.sv
module msg_stream_chk #(
  parameter int FIFO_DEPTH = 4,
  localparam int CNT_W     = $clog2(FIFO_DEPTH + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             mem_req_o,
  input logic             mem_rvalid_i,
  input logic             host_wr_i,
  input logic             host_rd_i,
  input logic             fifo_empty_o,
  input logic             fifo_full_o,
  input logic [CNT_W-1:0] fifo_count_o,
  input logic             busy_o,
  input logic             done_o
);
  logic pending_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           pending_q <= 1'b0;
    else if (mem_req_o)    pending_q <= 1'b1;
    else if (mem_rvalid_i) pending_q <= 1'b0;
  end

  a_r9_one_outstanding: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pending_q |-> !mem_req_o);

  a_r9_req_in_message: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> busy_o);

  a_r8_no_req_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_full_o |-> !mem_req_o);

  a_r8_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_count_o <= CNT_W'(FIFO_DEPTH));

  a_r5_done_after_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && $past(busy_o)));

  a_r5_busy_end_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);

  a_r7_host_write_blocked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && host_wr_i && !mem_rvalid_i && !host_rd_i) |=> $stable(fifo_count_o));

  a_r10_empty_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fifo_empty_o && !busy_o && !host_wr_i) |=> fifo_empty_o);
endmodule

bind msg_stream_seq msg_stream_chk #(
  .FIFO_DEPTH(FIFO_DEPTH)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .mem_req_o   (mem_req_o),
  .mem_rvalid_i(mem_rvalid_i),
  .host_wr_i   (host_wr_i),
  .host_rd_i   (host_rd_i),
  .fifo_empty_o(fifo_empty_o),
  .fifo_full_o (fifo_full_o),
  .fifo_count_o(fifo_count_o),
  .busy_o      (busy_o),
  .done_o      (done_o)
);

// File: tb/msg_stream_seq_tb.sv
module msg_stream_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 4;
  localparam int WD_CYCLES  = 150000;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cmd_valid_i = 1'b0;
  logic [7:0]  cmd_len_i = '0;
  logic [7:0]  cmd_addr_i = '0;
  logic        mem_req_o;
  logic [7:0]  mem_addr_o;
  logic        mem_rvalid_i = 1'b0;
  logic [15:0] mem_rdata_i = '0;
  logic        host_wr_i = 1'b0;
  logic [15:0] host_wdata_i = '0;
  logic        host_rd_i = 1'b0;
  logic [15:0] fifo_rdata_o;
  logic        fifo_empty_o;
  logic        fifo_full_o;
  logic [2:0]  fifo_count_o;
  logic        busy_o;
  logic        done_o;

  int total = 0;
  int bad   = 0;
  int lat_seed = 0;

  msg_stream_seq #(.FIFO_DEPTH(DEPTH)) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .cmd_valid_i(cmd_valid_i), .cmd_len_i(cmd_len_i), .cmd_addr_i(cmd_addr_i),
    .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o),
    .mem_rvalid_i(mem_rvalid_i), .mem_rdata_i(mem_rdata_i),
    .host_wr_i(host_wr_i), .host_wdata_i(host_wdata_i), .host_rd_i(host_rd_i),
    .fifo_rdata_o(fifo_rdata_o), .fifo_empty_o(fifo_empty_o),
    .fifo_full_o(fifo_full_o), .fifo_count_o(fifo_count_o),
    .busy_o(busy_o), .done_o(done_o)
  );

  initial forever #(CLK_PERIOD / 2) clk_i = ~clk_i;

  function automatic logic [15:0] mem_word(input int a);
    logic [7:0] aa;
    aa = a[7:0];
    return {aa ^ 8'h5C, aa};
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // memory model: latency 1..4 cycles, chosen from the address
  initial begin
    int cd;
    int pend_addr;
    bit pend;
    cd = 0; pend = 0; pend_addr = 0;
    forever begin
      @(negedge clk_i);
      mem_rvalid_i = 1'b0;
      if (cd > 0) begin
        cd--;
        if (cd == 0) begin
          mem_rvalid_i = 1'b1;
          mem_rdata_i  = mem_word(pend_addr);
          pend = 0;
        end
      end
      if (mem_req_o) begin
        chk(!pend, "R9", 1, 0);
        pend_addr = int'(mem_addr_o);
        cd   = 1 + ((pend_addr + lat_seed) % 4);
        pend = 1;
      end
    end
  end

  initial begin
    repeat (WD_CYCLES) @(posedge clk_i);
    bad++;
    total++;
    $display("FAIL watchdog act=%0d exp=%0d", WD_CYCLES, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  // rd_mode 0: read whenever possible, 1: every third cycle, 2: hold off until full
  task automatic run_msg(input int len, input int addr, input int rd_mode, input bit poke);
    int idx, cyc, done_cnt, full_hold;
    bit done_seen, seen_full, ok;
    string dtag;
    dtag = ((addr + len) > 255) ? "R4" : "R3";
    idx = 0; cyc = 0; done_cnt = 0; full_hold = 0;
    done_seen = 0; seen_full = 0;
    @(negedge clk_i);
    cmd_valid_i = 1'b1;
    cmd_len_i   = 8'(len);
    cmd_addr_i  = 8'(addr);
    while (1) begin
      @(negedge clk_i);
      cmd_valid_i = 1'b0;
      host_wr_i   = 1'b0;
      host_rd_i   = 1'b0;
      if (cyc == 0) chk(busy_o == 1'b1, "R5", int'(busy_o), 1);
      if (done_o) begin
        done_cnt++;
        done_seen = 1;
        chk(busy_o == 1'b0, "R5", int'(busy_o), 0);
      end
      if (done_seen && fifo_empty_o) break;
      if (poke && cyc == 2) begin
        chk(busy_o == 1'b1, "R6", int'(busy_o), 1);
        cmd_valid_i  = 1'b1;
        cmd_len_i    = 8'h00;
        cmd_addr_i   = 8'(addr + 100);
        host_wr_i    = 1'b1;
        host_wdata_i = 16'hBEEF;
      end
      if (rd_mode == 2 && !seen_full && fifo_full_o) begin
        chk(mem_req_o == 1'b0, "R8", int'(mem_req_o), 0);
        chk(int'(fifo_count_o) == DEPTH, "R8", int'(fifo_count_o), DEPTH);
        full_hold++;
        if (full_hold >= 4) seen_full = 1;
      end
      case (rd_mode)
        0:       ok = 1;
        1:       ok = (cyc % 3 == 0);
        default: ok = seen_full || done_seen;
      endcase
      if (ok && !fifo_empty_o) begin
        if (idx > len) chk(0, "R2", idx, len);
        else chk(fifo_rdata_o == mem_word(addr + idx), dtag,
                 int'(fifo_rdata_o), int'(mem_word(addr + idx)));
        host_rd_i = 1'b1;
        idx++;
      end
      cyc++;
    end
    chk(idx == len + 1, poke ? "R6" : "R2", idx, len + 1);
    chk(done_cnt == 1, "R5", done_cnt, 1);
    if (rd_mode == 2 && len + 1 > DEPTH) chk(seen_full, "R8", int'(seen_full), 1);
    if (poke) chk(int'(fifo_count_o) == 0, "R7", int'(fifo_count_o), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 reset state
    chk(busy_o == 1'b0, "R1", int'(busy_o), 0);
    chk(done_o == 1'b0, "R1", int'(done_o), 0);
    chk(mem_req_o == 1'b0, "R1", int'(mem_req_o), 0);
    chk(fifo_empty_o == 1'b1, "R1", int'(fifo_empty_o), 1);
    chk(int'(fifo_count_o) == 0, "R1", int'(fifo_count_o), 0);

    // R10 read on empty has no effect
    host_rd_i = 1'b1;
    @(negedge clk_i);
    host_rd_i = 1'b0;
    chk(int'(fifo_count_o) == 0, "R10", int'(fifo_count_o), 0);

    // R7 host writes when idle; fifth write dropped on full (R8)
    for (int i = 0; i < DEPTH + 1; i++) begin
      host_wr_i    = 1'b1;
      host_wdata_i = 16'(16'h1000 + i * 16'h0111);
      @(negedge clk_i);
    end
    host_wr_i = 1'b0;
    chk(int'(fifo_count_o) == DEPTH, "R7", int'(fifo_count_o), DEPTH);
    chk(fifo_full_o == 1'b1, "R8", int'(fifo_full_o), 1);
    for (int i = 0; i < DEPTH; i++) begin
      chk(int'(fifo_rdata_o) == 16'h1000 + i * 16'h0111, "R10",
          int'(fifo_rdata_o), 16'h1000 + i * 16'h0111);
      host_rd_i = 1'b1;
      @(negedge clk_i);
      host_rd_i = 1'b0;
    end
    chk(fifo_empty_o == 1'b1, "R10", int'(fifo_empty_o), 1);

    // length sweep with varied start, read pattern and latency
    for (int n = 0; n < 24; n++) begin
      lat_seed = n;
      run_msg(n, (n * 37) & 255, n % 3, (n % 4 == 2));
    end
    // address wrap cases
    lat_seed = 1;
    run_msg(9, 250, 0, 1'b0);
    run_msg(3, 255, 2, 1'b0);
    run_msg(0, 255, 1, 1'b0);
    // maximum length, wrapping
    lat_seed = 2;
    run_msg(255, 128, 0, 1'b1);
    run_msg(255, 0, 2, 1'b0);

    repeat (3) @(negedge clk_i);
    chk(busy_o == 1'b0 && fifo_empty_o == 1'b1, "R5", int'(busy_o), 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule